// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Controller

This block is the interlock and bypass control for a scalar pipeline with eight stages, in this order: two fetch stages (IF, IS), decode (D), execute (X), three data-cache stages (DF, DS, DC) and write-back (W). It keeps a small record of every instruction from X through W: whether the slot holds an instruction, whether it writes a register, which register, and whether it is a load or a branch. From that record it chooses a bypass source for each of the two execute operands, and it holds decode whenever a load result would arrive too late.

Two further events are handled. First, a branch in X that resolves taken, against the static not-taken guess, kills the two wrong-path instructions in IF and IS. The instruction in D is the delay slot and goes on. Second, a failed tag check on a load in DC freezes the whole pipeline. The load is pulled back so that it does not reach W, and every stage then waits for a refill pulse. After the pulse the load occupies DC again.

Decode hands instructions to execute through a valid/ready pair. An instruction moves from D into X only on a clock edge where `d_valid` and `d_ready` are both high. While `d_ready` is low, the fetch stages and D must keep their contents. `d_ready` does not depend on `d_valid`. A cycle without a transfer puts a bubble into X.

Top module: `pipe8_hazard_ctrl`

## Requirements
- R1: After reset all tracked slots are empty: `d_ready`=1, `fwd_a`=`fwd_b`=0, and `x_bubble`, `hold_all`, `dc_backup`, `miss_wait` and `kill_fetch` are all 0.
- R2: Each operand select takes one of five codes: 0 register file, 1 DF, 2 DS, 3 DC, 4 W. When the operand's register matches a writing instruction in one of those stages, the select names that stage. When several match, the youngest one (closest to X) wins. Stages whose destination differs are skipped.
- R3: Register 0 never matches, so an operand that reads register 0 always gets code 0.
- R4: A load result is never taken from DF. For an operand that depends on a load, the select names DC once the two load-use bubbles have passed.
- R5: An instruction in D that reads the destination of a load in X or in DF causes `d_ready`=0 and `x_bubble`=1. This gives two bubbles when the dependent instruction directly follows the load, one bubble with one independent instruction between them, and none with two.
- R6: A D-stage instruction presented with `d_valid`=0 never enters X, so it can never become a bypass source.
- R7: When `dc_miss` is high and DC holds a load, `dc_backup` and `hold_all` are high in that same cycle and `miss_wait` is high from the next cycle. The load does not pass into W, and in the first cycle after the refill it is in DC again (a dependent operand in X selects code 3).
- R8: While `miss_wait` is high, DC is never given as a bypass source.
- R9: `refill_done` has no effect outside the wait state. `dc_miss` has no effect when DC does not hold a load.
- R10: `kill_fetch` is high in the same cycle that `br_taken_x` is high, but only if X holds a branch and the pipeline is not held. The delay-slot instruction in D is still accepted (`d_ready`=1).
- R11: While `miss_wait` is high, `hold_all`=1 and `d_ready`=0, and no tracked slot moves, so both operand selects stay stable until the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| d_valid | input | 1 | D holds an instruction to hand to X |
| d_ready | output | 1 | X accepts the D instruction at this edge |
| d_rd | input | 5 | Destination register of the D instruction |
| d_wr | input | 1 | D instruction writes `d_rd` |
| d_rs1 | input | 5 | First source register of the D instruction |
| d_use1 | input | 1 | First source is read |
| d_rs2 | input | 5 | Second source register of the D instruction |
| d_use2 | input | 1 | Second source is read |
| d_load | input | 1 | D instruction is a load |
| d_branch | input | 1 | D instruction is a branch |
| br_taken_x | input | 1 | Branch in X resolved taken (guess was not-taken) |
| dc_miss | input | 1 | Tag check of the DC instruction failed |
| refill_done | input | 1 | Pulse: missing line has been filled |
| x_bubble | output | 1 | X receives a load-use bubble this edge |
| hold_all | output | 1 | Every stage keeps its contents this edge |
| dc_backup | output | 1 | Missing load is pulled back from the DC-to-W handoff |
| miss_wait | output | 1 | Waiting for the refill |
| kill_fetch | output | 1 | Turn IF and IS into bubbles |
| fwd_a | output | 3 | Bypass source for the first X operand |
| fwd_b | output | 3 | Bypass source for the second X operand |

## Verification
The hardest state to reach is the refill replay. A load has to sit in DC while a dependent instruction sits in X, and it has to get there without tripping the load-use interlock. The bench therefore issues the load, then two idle cycles, then the consumer, so that the consumer reaches X on the same edge that the load reaches DC. It raises `dc_miss` in that cycle, keeps the pipeline waiting for several cycles, and then pulses `refill_done`. The consumer's select reads 0 during the wait and 3 right after the refill, which shows that the load never reached W and came back into DC.

// File: rtl/pipe8_pkg.sv
`timescale 1ns/1ps
package pipe8_pkg;
  localparam int REG_IDX_W = 5;
  // tracked slots: X, DF, DS, DC, W (index 0 is the youngest)
  localparam int N_TRACK = 5;
  localparam int IDX_X   = 0;
  localparam int IDX_DF  = 1;
  localparam int IDX_DC  = 3;
  localparam int N_PROD  = N_TRACK - 1;
  localparam int SEL_W   = $clog2(N_PROD + 1);
  // load-use window: loads in X or DF block a dependent in D
  localparam int LU_GAP  = 2;
  // first producer index (0 = DF) allowed to supply load data
  localparam int LOAD_MIN = 1;

  typedef logic [REG_IDX_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     valid;
    logic     wr;
    logic     ld;
    logic     br;
    reg_idx_t rd;
  } slot_t;

  typedef enum logic {ST_RUN = 1'b0, ST_WAIT = 1'b1} miss_st_e;
endpackage

// File: rtl/pipe8_slot_track.sv
`timescale 1ns/1ps
module pipe8_slot_track
  import pipe8_pkg::*;
#(
  parameter int DEPTH = N_TRACK
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic                  backup,
  input  slot_t                 x_in,
  input  reg_idx_t              rs1_in,
  input  reg_idx_t              rs2_in,
  input  logic                  u1_in,
  input  logic                  u2_in,
  output slot_t [DEPTH-1:0]     stg,
  output reg_idx_t              x_rs1,
  output reg_idx_t              x_rs2,
  output logic                  x_u1,
  output logic                  x_u2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      x_rs1 <= '0;
      x_rs2 <= '0;
      x_u1  <= 1'b0;
      x_u2  <= 1'b0;
    end else if (advance) begin
      stg[0] <= x_in;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      x_rs1 <= rs1_in;
      x_rs2 <= rs2_in;
      x_u1  <= u1_in;
      x_u2  <= u2_in;
    end else if (backup) begin
      // missing instruction stays in DC; write-back receives a bubble
      stg[DEPTH-1] <= '0;
    end
  end
endmodule

// File: rtl/pipe8_fwd_pick.sv
`timescale 1ns/1ps
module pipe8_fwd_pick
  import pipe8_pkg::*;
#(
  parameter int NPROD = N_PROD,
  parameter int LDMIN = LOAD_MIN,
  localparam int SW   = $clog2(NPROD + 1)
) (
  input  reg_idx_t             src,
  input  logic                 use_src,
  input  slot_t [NPROD-1:0]    prod,
  input  logic  [NPROD-1:0]    prod_en,
  output logic  [SW-1:0]       sel
);
  always_comb begin
    sel = '0;
    // oldest first so the youngest match overrides
    for (int i = NPROD - 1; i >= 0; i--) begin
      if (use_src && (src != '0) && prod_en[i] && prod[i].valid &&
          prod[i].wr && (prod[i].rd == src) && !(prod[i].ld && (i < LDMIN)))
        sel = SW'(i + 1);
    end
  end
endmodule

// File: rtl/pipe8_ld_use.sv
`timescale 1ns/1ps
module pipe8_ld_use
  import pipe8_pkg::*;
#(
  parameter int GAP = LU_GAP
) (
  input  reg_idx_t           rs1,
  input  reg_idx_t           rs2,
  input  logic               u1,
  input  logic               u2,
  input  slot_t [GAP-1:0]    older,
  output logic               stall
);
  logic [GAP-1:0] hit;

  for (genvar g = 0; g < GAP; g++) begin : g_win
    assign hit[g] = older[g].valid && older[g].ld && older[g].wr &&
                    (older[g].rd != '0) &&
                    ((u1 && (rs1 == older[g].rd)) || (u2 && (rs2 == older[g].rd)));
  end

  assign stall = |hit;
endmodule

// File: rtl/pipe8_miss_ctl.sv
`timescale 1ns/1ps
module pipe8_miss_ctl
  import pipe8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dc_miss,
  input  logic dc_has_load,
  input  logic refill_done,
  output logic backup,
  output logic waiting,
  output logic hold_all
);
  miss_st_e st_q, st_d;

  assign backup   = (st_q == ST_RUN) && dc_miss && dc_has_load;
  assign waiting  = (st_q == ST_WAIT);
  assign hold_all = backup || waiting;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (backup) st_d = ST_WAIT;
      ST_WAIT: if (refill_done) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/pipe8_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe8_hazard_ctrl
  import pipe8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 d_valid,
  output logic                 d_ready,
  input  logic [REG_IDX_W-1:0] d_rd,
  input  logic                 d_wr,
  input  logic [REG_IDX_W-1:0] d_rs1,
  input  logic                 d_use1,
  input  logic [REG_IDX_W-1:0] d_rs2,
  input  logic                 d_use2,
  input  logic                 d_load,
  input  logic                 d_branch,
  input  logic                 br_taken_x,
  input  logic                 dc_miss,
  input  logic                 refill_done,
  output logic                 x_bubble,
  output logic                 hold_all,
  output logic                 dc_backup,
  output logic                 miss_wait,
  output logic                 kill_fetch,
  output logic [SEL_W-1:0]     fwd_a,
  output logic [SEL_W-1:0]     fwd_b
);
  slot_t [N_TRACK-1:0] stg;
  slot_t               x_in;
  reg_idx_t            x_rs1, x_rs2;
  logic                x_u1, x_u2;
  logic                ld_stall;
  logic                take;
  logic [N_PROD-1:0]   prod_en;
  reg_idx_t            op_src [2];
  logic                op_use [2];
  logic [SEL_W-1:0]    op_sel [2];

  pipe8_miss_ctl u_miss (
    .clk        (clk),
    .rst_n      (rst_n),
    .dc_miss    (dc_miss),
    .dc_has_load(stg[IDX_DC].valid && stg[IDX_DC].ld),
    .refill_done(refill_done),
    .backup     (dc_backup),
    .waiting    (miss_wait),
    .hold_all   (hold_all)
  );

  pipe8_ld_use #(.GAP(LU_GAP)) u_lduse (
    .rs1  (d_rs1),
    .rs2  (d_rs2),
    .u1   (d_use1),
    .u2   (d_use2),
    .older(stg[LU_GAP-1:0]),
    .stall(ld_stall)
  );

  assign d_ready  = !hold_all && !ld_stall;
  assign x_bubble = ld_stall && !hold_all;
  assign take     = d_valid && d_ready;

  always_comb begin
    x_in = '0;
    if (take) begin
      x_in.valid = 1'b1;
      x_in.wr    = d_wr;
      x_in.ld    = d_load;
      x_in.br    = d_branch;
      x_in.rd    = d_rd;
    end
  end

  pipe8_slot_track #(.DEPTH(N_TRACK)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(!hold_all),
    .backup (dc_backup),
    .x_in   (x_in),
    .rs1_in (take ? d_rs1 : '0),
    .rs2_in (take ? d_rs2 : '0),
    .u1_in  (take && d_use1),
    .u2_in  (take && d_use2),
    .stg    (stg),
    .x_rs1  (x_rs1),
    .x_rs2  (x_rs2),
    .x_u1   (x_u1),
    .x_u2   (x_u2)
  );

  // producer enables, bit 0 = DF ... bit N_PROD-1 = W; DC data is void while held
  always_comb begin
    prod_en = '1;
    prod_en[IDX_DC - IDX_DF] = !hold_all;
  end

  assign op_src[0] = x_rs1;
  assign op_src[1] = x_rs2;
  assign op_use[0] = x_u1 && stg[IDX_X].valid;
  assign op_use[1] = x_u2 && stg[IDX_X].valid;

  for (genvar k = 0; k < 2; k++) begin : g_op
    pipe8_fwd_pick #(.NPROD(N_PROD), .LDMIN(LOAD_MIN)) u_pick (
      .src    (op_src[k]),
      .use_src(op_use[k]),
      .prod   (stg[N_TRACK-1:IDX_DF]),
      .prod_en(prod_en),
      .sel    (op_sel[k])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  assign kill_fetch = br_taken_x && stg[IDX_X].valid && stg[IDX_X].br && !hold_all;
endmodule

// File: rtl/pipe8_hazard_ctrl_chk.sv
`timescale 1ns/1ps
module pipe8_hazard_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       d_ready,
  input logic       x_bubble,
  input logic       hold_all,
  input logic       dc_backup,
  input logic       miss_wait,
  input logic       kill_fetch,
  input logic       refill_done,
  input logic [2:0] fwd_a,
  input logic [2:0] fwd_b
);
  p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a <= 3'd4) && (fwd_b <= 3'd4));

  p_bubble_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    x_bubble |-> !d_ready);

  p_backup_to_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dc_backup |=> miss_wait);

  p_wait_no_dc_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_wait |-> (fwd_a != 3'd3) && (fwd_b != 3'd3));

  p_refill_exits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_wait && refill_done) |=> !miss_wait);

  p_no_kill_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_all |-> !kill_fetch);

  p_wait_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    miss_wait |-> (hold_all && !d_ready));

  p_wait_sel_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_wait && !refill_done) |=> ($stable(fwd_a) && $stable(fwd_b)));
endmodule

bind pipe8_hazard_ctrl pipe8_hazard_ctrl_chk chk_i (.*);

// File: tb/pipe8_hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
module pipe8_hazard_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       d_valid, d_wr, d_use1, d_use2, d_load, d_branch;
  logic [4:0] d_rd, d_rs1, d_rs2;
  logic       br_taken_x, dc_miss, refill_done;
  logic       d_ready, x_bubble, hold_all, dc_backup, miss_wait, kill_fetch;
  logic [2:0] fwd_a, fwd_b;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pipe8_hazard_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_ready(d_ready),
    .d_rd(d_rd), .d_wr(d_wr), .d_rs1(d_rs1), .d_use1(d_use1),
    .d_rs2(d_rs2), .d_use2(d_use2), .d_load(d_load), .d_branch(d_branch),
    .br_taken_x(br_taken_x), .dc_miss(dc_miss), .refill_done(refill_done),
    .x_bubble(x_bubble), .hold_all(hold_all), .dc_backup(dc_backup),
    .miss_wait(miss_wait), .kill_fetch(kill_fetch), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input int rd, input logic wr, input int rs1,
                     input logic u1, input int rs2, input logic u2,
                     input logic ld, input logic br);
    d_valid = v; d_rd = 5'(rd); d_wr = wr; d_rs1 = 5'(rs1); d_use1 = u1;
    d_rs2 = 5'(rs2); d_use2 = u2; d_load = ld; d_branch = br;
  endtask

  task automatic idle();
    put(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic flush();
    idle();
    br_taken_x = 0; dc_miss = 0; refill_done = 0;
    repeat (6) tick();
  endtask

  // producer writes r5, consumer reads r5 after g idle cycles
  task automatic t_gap(input int g, input int exp, input bit on_b, input string tag);
    flush();
    put(1, 5, 1, 0, 0, 0, 0, 0, 0); tick();
    repeat (g) begin idle(); tick(); end
    if (on_b) put(1, 8, 1, 0, 0, 5, 1, 0, 0);
    else      put(1, 8, 1, 5, 1, 0, 0, 0, 0);
    tick(); idle(); #1;
    chk(tag, on_b ? int'(fwd_b) : int'(fwd_a), exp);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 d_ready", d_ready, 1);
    chk("R1 fwd_a", fwd_a, 0);
    chk("R1 fwd_b", fwd_b, 0);
    chk("R1 x_bubble", x_bubble, 0);
    chk("R1 hold_all", hold_all, 0);
    chk("R1 miss_wait", miss_wait, 0);
    chk("R1 kill_fetch", kill_fetch, 0);
  endtask

  task automatic t_bypass();
    t_gap(0, 1, 0, "R2 DF source");
    t_gap(1, 2, 0, "R2 DS source");
    t_gap(2, 3, 1, "R2 DC source on b");
    t_gap(3, 4, 0, "R2 W source");
    t_gap(4, 0, 0, "R2 register file");
  endtask

  task automatic t_priority();
    flush();
    put(1, 5, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 5, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 9, 1, 5, 1, 0, 0, 0, 0); tick(); idle(); #1;
    chk("R2 youngest wins", fwd_a, 1);
    flush();
    put(1, 5, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 6, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 9, 1, 5, 1, 6, 1, 0, 0); tick(); idle(); #1;
    chk("R2 skip other dest a", fwd_a, 2);
    chk("R2 skip other dest b", fwd_b, 1);
  endtask

  task automatic t_r0();
    flush();
    put(1, 0, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 9, 1, 0, 1, 0, 1, 0, 0); tick(); idle(); #1;
    chk("R3 r0 a", fwd_a, 0);
    chk("R3 r0 b", fwd_b, 0);
  endtask

  task automatic t_invalid();
    flush();
    put(0, 5, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 9, 1, 5, 1, 0, 0, 0, 0); tick(); idle(); #1;
    chk("R6 invalid never enters", fwd_a, 0);
  endtask

  task automatic t_load_use();
    // adjacent: two bubbles
    flush();
    put(1, 9, 1, 0, 0, 0, 0, 1, 0); tick();
    put(1, 10, 1, 9, 1, 0, 0, 0, 0); #1;
    chk("R5 adj stall 1 ready", d_ready, 0);
    chk("R5 adj stall 1 bubble", x_bubble, 1);
    tick(); #1;
    chk("R5 adj stall 2 ready", d_ready, 0);
    tick(); #1;
    chk("R5 adj released", d_ready, 1);
    tick(); idle(); #1;
    chk("R4 adj load source", fwd_a, 3);
    // one independent between: one bubble
    flush();
    put(1, 9, 1, 0, 0, 0, 0, 1, 0); tick();
    put(1, 11, 1, 3, 1, 0, 0, 0, 0); #1;
    chk("R5 independent accepted", d_ready, 1);
    tick();
    put(1, 10, 1, 0, 0, 9, 1, 0, 0); #1;
    chk("R5 gap1 stall", d_ready, 0);
    tick(); #1;
    chk("R5 gap1 released", d_ready, 1);
    tick(); idle(); #1;
    chk("R4 gap1 load source b", fwd_b, 3);
    // two between: no bubble
    flush();
    put(1, 9, 1, 0, 0, 0, 0, 1, 0); tick();
    put(1, 11, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 12, 1, 0, 0, 0, 0, 0, 0); tick();
    put(1, 10, 1, 9, 1, 0, 0, 0, 0); #1;
    chk("R5 gap2 no stall", d_ready, 1);
    tick(); idle(); #1;
    chk("R4 gap2 load source", fwd_a, 3);
  endtask

  task automatic t_miss();
    logic [2:0] hold_sel;
    flush();
    put(1, 12, 1, 0, 0, 0, 0, 1, 0); tick();
    idle(); tick();
    idle(); tick();
    put(1, 13, 1, 12, 1, 0, 0, 0, 0); #1;
    chk("R5 load in DS no stall", d_ready, 1);
    tick(); idle();
    dc_miss = 1; #1;
    chk("R7 backup pulse", dc_backup, 1);
    chk("R7 hold in miss cycle", hold_all, 1);
    tick(); dc_miss = 0; #1;
    chk("R7 waiting", miss_wait, 1);
    chk("R8 no DC source while waiting", fwd_a, 0);
    hold_sel = fwd_a;
    br_taken_x = 1; #1;
    chk("R10 no kill while held", kill_fetch, 0);
    br_taken_x = 0;
    repeat (3) tick();
    #1;
    chk("R11 still waiting", miss_wait, 1);
    chk("R11 d_ready low", d_ready, 0);
    chk("R11 select stable", fwd_a, hold_sel);
    refill_done = 1; tick(); refill_done = 0; #1;
    chk("R7 wait left", miss_wait, 0);
    chk("R7 hold released", hold_all, 0);
    chk("R7 load back in DC", fwd_a, 3);
  endtask

  task automatic t_ignored();
    flush();
    refill_done = 1; tick(); refill_done = 0; #1;
    chk("R9 stray refill", miss_wait, 0);
    put(1, 3, 1, 0, 0, 0, 0, 0, 0); tick();
    idle(); repeat (3) tick();
    dc_miss = 1; #1;
    chk("R9 miss on non-load hold", hold_all, 0);
    chk("R9 miss on non-load backup", dc_backup, 0);
    tick(); dc_miss = 0; #1;
    chk("R9 miss on non-load wait", miss_wait, 0);
  endtask

  task automatic t_branch();
    flush();
    put(1, 0, 0, 0, 0, 0, 0, 0, 1); tick();
    put(1, 7, 1, 0, 0, 0, 0, 0, 0); #1;
    chk("R10 no kill when not taken", kill_fetch, 0);
    br_taken_x = 1; #1;
    chk("R10 kill on taken", kill_fetch, 1);
    chk("R10 delay slot accepted", d_ready, 1);
    tick(); br_taken_x = 0;
    put(1, 8, 1, 7, 1, 0, 0, 0, 0); tick(); idle(); #1;
    chk("R10 delay slot entered", fwd_a, 1);
    flush();
    put(1, 4, 1, 0, 0, 0, 0, 0, 0); tick(); idle();
    br_taken_x = 1; #1;
    chk("R10 non-branch in X", kill_fetch, 0);
    br_taken_x = 0;
  endtask

  initial begin
    rst_n = 0;
    idle();
    br_taken_x = 0; dc_miss = 0; refill_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bypass();
    t_priority();
    t_r0();
    t_invalid();
    t_load_use();
    t_miss();
    t_ignored();
    t_branch();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule